// File: doc/BRIEF.md
# Horizontal Microcode Sequencer

This block steers a single-bus datapath from a horizontally encoded control store. The store holds 512 microinstructions of 36 bits each. A microinstruction register holds the word being executed. Its fields drive the following controls directly:

- write enables for the result bus, where any number may be set together;
- a compressed 4-bit source select, decoded to a one-hot enable for the operand bus;
- eight ALU/shifter control bits;
- memory read, write and fetch commands.

The registers, ALU, shifter and memory are outside the block. The block sees them only through the ALU negative/zero results and the byte register value used for dispatch.

Each microinstruction takes two clocks. The first is the execute cycle, which drives the datapath controls. At its end the N and Z results are captured in two flag flops. The second is the sequence cycle. In this cycle the memory command strobes are issued, which starts the memory operation after the address register was loaded in the execute cycle. The next address is built in the same cycle from the word's 9-bit successor field, the latched flags and the dispatch byte. At the end of the sequence cycle the word at that address is loaded.

The store is filled through a write port, normally while reset is held.

Top module: `ucode_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, `upc` is 0 and the all-zero word is executing. All write enables, ALU bits and memory strobes are 0, and `b_src_oh` is 0x0001.
- R2: A clock edge with `cs_we` high writes `cs_wdata` into the store word at `cs_addr`. That word appears on the controls when the sequencer next reaches that address.
- R3: Word layout: bits [15:7] are the nine result-bus write enables. They appear unchanged on `c_wr_en` in the execute cycle, in any combination, and are 0 in the sequence cycle.
- R4: Bits [3:0] are the operand source number. `b_src_oh` carries a single 1 at that bit position in the execute cycle and is 0 in the sequence cycle.
- R5: Bits [23:16] appear on `alu_ctl` in the execute cycle and are 0 in the sequence cycle.
- R6: Bit 6 (write), bit 5 (read) and bit 4 (fetch) appear on `mem_wr`, `mem_rd` and `mem_fetch` in the sequence cycle only, for exactly one clock.
- R7: Execute and sequence cycles alternate strictly. `upc`, the address of the executing word, changes only at the end of a sequence cycle.
- R8: Bits [35:27] are the successor address. With bits 26..24 clear, the next `upc` equals this field.
- R9: `alu_n` and `alu_z` are captured at the end of the execute cycle. If bit 25 is set with captured N=1, or bit 24 is set with captured Z=1, bit 8 of the next address is forced to 1.
- R10: With bit 26 set, the low 8 bits of the next address are the successor field ORed with `mbr`, as sampled at the end of the sequence cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_n | input | 1 | ALU negative result |
| alu_z | input | 1 | ALU zero result |
| mbr | input | 8 | Byte register value for dispatch |
| cs_we | input | 1 | Store write enable |
| cs_addr | input | 9 | Store write address |
| cs_wdata | input | 36 | Store write data |
| c_wr_en | output | 9 | Result-bus register write enables |
| b_src_oh | output | 16 | One-hot operand-bus source enable |
| alu_ctl | output | 8 | ALU/shifter controls |
| mem_rd | output | 1 | Memory read start |
| mem_wr | output | 1 | Memory write start |
| mem_fetch | output | 1 | Instruction byte fetch start |
| upc | output | 9 | Address of the executing microinstruction |

## Verification
The properties check on every cycle that at most one operand source is enabled. They also check that execute and sequence cycles alternate, that `upc` holds across an execute cycle, and that a memory strobe never coincides with datapath controls. Correct successor addresses are checked only by the bench, which runs a reference sequencer over a store filled with random words. The reference covers conditional forcing of the top address bit from the flags captured one cycle earlier, and dispatch on a byte that changes every cycle. It also covers a reset taken in the middle of a run.

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int ADDR_W = 9,
  parameter int CW_W   = 9,
  parameter int SEL_W  = 4,
  parameter int ALU_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alu_n,
  input  logic                  alu_z,
  input  logic [ADDR_W-2:0]     mbr,
  input  logic                  cs_we,
  input  logic [ADDR_W-1:0]     cs_addr,
  input  logic [ADDR_W+SEL_W+CW_W+ALU_W+5:0] cs_wdata,
  output logic [CW_W-1:0]       c_wr_en,
  output logic [(1<<SEL_W)-1:0] b_src_oh,
  output logic [ALU_W-1:0]      alu_ctl,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  mem_fetch,
  output logic [ADDR_W-1:0]     upc
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NSRC   = 1 << SEL_W;
  localparam int MBR_W  = ADDR_W - 1;
  localparam int FET_B  = SEL_W;
  localparam int RD_B   = SEL_W + 1;
  localparam int WR_B   = SEL_W + 2;
  localparam int CW_LO  = SEL_W + 3;
  localparam int ALU_LO = CW_LO + CW_W;
  localparam int JZ_B   = ALU_LO + ALU_W;
  localparam int JN_B   = JZ_B + 1;
  localparam int DSP_B  = JZ_B + 2;
  localparam int NXT_LO = JZ_B + 3;
  localparam int WORD_W = NXT_LO + ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] mir;
  logic [ADDR_W-1:0] upc_q;
  logic              n_q, z_q, seq_q;

  always_ff @(posedge clk)
    if (cs_we) store[cs_addr] <= cs_wdata;

  wire             jam_hi = (mir[JN_B] & n_q) | (mir[JZ_B] & z_q);
  wire [MBR_W-1:0] disp   = mir[DSP_B] ? mbr : '0;
  wire [ADDR_W-1:0] nxt   = {mir[NXT_LO+ADDR_W-1] | jam_hi,
                             mir[NXT_LO +: MBR_W] | disp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= 1'b0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      upc_q <= '0;
      mir   <= '0;
    end else begin
      seq_q <= ~seq_q;
      if (!seq_q) begin
        n_q <= alu_n;
        z_q <= alu_z;
      end else begin
        upc_q <= nxt;
        mir   <= store[nxt];
      end
    end
  end

  wire exec = ~seq_q;

  assign c_wr_en   = exec ? mir[CW_LO +: CW_W] : '0;
  assign alu_ctl   = exec ? mir[ALU_LO +: ALU_W] : '0;
  assign b_src_oh  = exec ? ({{(NSRC-1){1'b0}}, 1'b1} << mir[SEL_W-1:0]) : '0;
  assign mem_rd    = seq_q & mir[RD_B];
  assign mem_wr    = seq_q & mir[WR_B];
  assign mem_fetch = seq_q & mir[FET_B];
  assign upc       = upc_q;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
  parameter int ADDR_W = 9,
  parameter int CW_W   = 9,
  parameter int SEL_W  = 4,
  parameter int ALU_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CW_W-1:0]       c_wr_en,
  input logic [(1<<SEL_W)-1:0] b_src_oh,
  input logic [ALU_W-1:0]      alu_ctl,
  input logic                  mem_rd,
  input logic                  mem_wr,
  input logic                  mem_fetch,
  input logic [ADDR_W-1:0]     upc
);
  // R4
  b_src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(b_src_oh));

  // R7
  exec_to_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_src_oh != '0) |=> (b_src_oh == '0));

  // R7
  seq_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_src_oh == '0) |=> (b_src_oh != '0));

  // R7
  upc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_src_oh != '0) |=> $stable(upc));

  // R6
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd | mem_wr | mem_fetch) |-> (c_wr_en == '0 && alu_ctl == '0 && b_src_oh == '0));

  // R6
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd | mem_wr | mem_fetch) |=> !(mem_rd | mem_wr | mem_fetch));
endmodule

bind ucode_seq ucode_seq_chk #(
  .ADDR_W(ADDR_W), .CW_W(CW_W), .SEL_W(SEL_W), .ALU_W(ALU_W)
) chk (
  .clk(clk), .rst_n(rst_n), .c_wr_en(c_wr_en), .b_src_oh(b_src_oh),
  .alu_ctl(alu_ctl), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_fetch(mem_fetch), .upc(upc)
);

// File: tb/tb_ucode_seq.sv
module tb_ucode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_n = 1'b0, alu_z = 1'b0;
  logic [7:0]  mbr = '0;
  logic        cs_we = 1'b0;
  logic [8:0]  cs_addr = '0;
  logic [35:0] cs_wdata = '0;
  logic [8:0]  c_wr_en;
  logic [15:0] b_src_oh;
  logic [7:0]  alu_ctl;
  logic        mem_rd, mem_wr, mem_fetch;
  logic [8:0]  upc;

  always #4 clk = ~clk;

  ucode_seq dut (
    .clk(clk), .rst_n(rst_n), .alu_n(alu_n), .alu_z(alu_z), .mbr(mbr),
    .cs_we(cs_we), .cs_addr(cs_addr), .cs_wdata(cs_wdata),
    .c_wr_en(c_wr_en), .b_src_oh(b_src_oh), .alu_ctl(alu_ctl),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_fetch(mem_fetch), .upc(upc)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  bit [35:0] m_store [512];
  bit [35:0] m_word;
  int        m_pc;
  bit        m_n, m_z, m_seq;
  string     pc_tag = "R1";

  always @(posedge clk) begin
    bit [35:0] w_old;
    int nxt;
    if (!rst_n) begin
      m_word = '0; m_pc = 0; m_n = 0; m_z = 0; m_seq = 0; pc_tag = "R1";
    end else if (!m_seq) begin
      m_n = alu_n; m_z = alu_z; m_seq = 1;
    end else begin
      w_old = m_word;
      nxt = int'(w_old[35:27]);
      if ((w_old[25] && m_n) || (w_old[24] && m_z)) nxt = nxt | 256;
      if (w_old[26]) nxt = nxt | int'(mbr);
      if (w_old[26]) pc_tag = "R10";
      else if (w_old[25] || w_old[24]) pc_tag = "R9";
      else pc_tag = "R8";
      m_pc = nxt; m_word = m_store[nxt]; m_seq = 0;
    end
    if (cs_we) m_store[cs_addr] = cs_wdata;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    bit ex;
    ex = !m_seq;
    chk(rst_n ? "R3 (R2 store word)" : "R1", c_wr_en, ex ? m_word[15:7] : 0);
    chk(rst_n ? "R4" : "R1", b_src_oh, ex ? (16'd1 << m_word[3:0]) : 0);
    chk(rst_n ? "R5" : "R1", alu_ctl, ex ? m_word[23:16] : 0);
    chk(rst_n ? "R6" : "R1", {mem_wr, mem_rd, mem_fetch}, ex ? 0 : m_word[6:4]);
    chk(rst_n ? pc_tag : "R1", upc, m_pc);
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    compare_all();
    alu_n = 1'($urandom);
    alu_z = 1'($urandom);
    mbr   = 8'($urandom);
  endtask

  initial begin
    repeat (3) step();
    // R2: fill the store through the write port while reset is held
    for (int a = 0; a < 512; a++) begin
      cs_we = 1'b1;
      cs_addr = 9'(a);
      cs_wdata = {4'($urandom), 32'($urandom)};
      if (a == 0) cs_wdata = {9'd5, 3'b000, 8'hA5, 9'h1FF, 3'b010, 4'd15};
      if (a == 5) cs_wdata = {9'd7, 3'b010, 8'h00, 9'h000, 3'b101, 4'd0};
      step();
    end
    cs_we = 1'b0;
    step();
    rst_n = 1'b1;
    // R7 R8 R9 R10: free run through random microcode
    repeat (3000) step();
    // R1: reset taken mid-run
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (600) step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule